// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Silence Watchdog

This block moves a single logic level across a channel that can carry only short pulses. The transmit half samples the level through a two-stage synchroniser, turns each rising change into a pulse on a set line and each falling change into a pulse on a clear line, and, when the level has been quiet for a programmable number of cycles, repeats a pulse that matches the present level. Because the channel carries no steady state, these repeated pulses are what keep the far side correct when the input does not change.

The receive half holds the level in a bistable register. A set pulse drives it high and a clear pulse drives it low. A silence counter runs alongside it. If no usable pulse arrives within a longer window, the far side is treated as absent and the output is forced low. It stays low until the next usable pulse. The two halves share one clock. They are exposed as separate port groups so that the channel between them can be looped back, broken or driven directly.

Top module: `edge_pulse_link`

## Requirements
- R1: A rising change on `data_in` raises `set_out` for PULSE_W cycles. The pulse first appears on the third rising clock edge after the change is sampled (two synchroniser stages plus the pulse register).
- R2: A falling change on `data_in` raises `clr_out` in the same way. `set_out` and `clr_out` are never high together.
- R3: When the synchronised input has not changed for REFRESH_CYC cycles, the transmitter sends a pulse of the current level (`set_out` if high, `clr_out` if low). It repeats this every REFRESH_CYC cycles. The interval counter restarts on every input change and after every refresh pulse.
- R4: A usable pulse is `set_in`=1 with `clr_in`=0, or `clr_in`=1 with `set_in`=0. On the clock edge that samples it, `data_out` becomes 1 or 0 respectively.
- R5: After WDOG_CYC consecutive clock edges with no usable pulse, `data_out` is forced to 0. It stays 0 whatever the input does until a usable pulse arrives.
- R6: `set_in`=1 together with `clr_in`=1 is ignored. It neither changes `data_out` nor restarts the silence window.
- R7: While reset is held, and right after it is released, `data_out`, `set_out` and `clr_out` are 0. The watchdog starts in the expired state.
- R8: When a usable pulse arrives on the same edge on which the silence window would expire, the pulse wins. `data_out` takes the pulse's level and a fresh window of WDOG_CYC edges begins.
- R9: With the outputs looped back to the inputs and REFRESH_CYC < WDOG_CYC, a constant `data_in` is reproduced on `data_out` indefinitely and the watchdog never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Level to be carried, asynchronous to clk |
| set_out | output | 1 | Transmit pulse for a high level |
| clr_out | output | 1 | Transmit pulse for a low level |
| set_in | input | 1 | Received pulse for a high level |
| clr_in | input | 1 | Received pulse for a low level |
| data_out | output | 1 | Reproduced level, low when the sender is silent |

## Verification
On the receive side, the arrival of a pulse and the expiry of the silence window can land on the same edge. The bench breaks the loop, injects one set pulse, counts exactly WDOG_CYC edges and injects the next pulse on the expiry edge. A correct design keeps `data_out` high and then holds it for a full further window before it drops. The same timing is used with a simultaneous set and clear on the expiry edge, where the output must fall. A cycle-accurate behavioural model in the bench judges every cycle of both cases alongside the directed checks.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // Counter width able to hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // True when a counter running from zero has reached its last value
  function automatic logic at_last(input logic [31:0] cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

  // Only a single asserted pulse line carries information
  function automatic logic pulse_usable(input logic set_l, input logic clr_l);
    return set_l ^ clr_l;
  endfunction

  // Pulse-line level: set is used for a high level, clear for a low level
  function automatic logic [1:0] encode_level(input logic lvl, input logic active);
    return active ? (lvl ? 2'b10 : 2'b01) : 2'b00;
  endfunction

endpackage

// File: rtl/epl_sync.sv
module epl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/epl_tx.sv
module epl_tx
  import epl_pkg::*;
#(
  parameter int unsigned PULSE_W     = 1,
  parameter int unsigned REFRESH_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic set_o,
  output logic clr_o,
  output logic rise_o,
  output logic fall_o,
  output logic refresh_o
);
  localparam int unsigned IW = cnt_width(REFRESH_CYC);
  localparam int unsigned LW = cnt_width(PULSE_W + 1);

  logic          prev_q;
  logic [IW-1:0] idle_q;
  logic [LW-1:0] left_q;
  logic          kind_q;
  logic          edge_seen;
  logic          due;
  logic          start;
  logic [1:0]    lines;

  assign rise_o    = lvl_i & ~prev_q;
  assign fall_o    = ~lvl_i & prev_q;
  assign edge_seen = rise_o | fall_o;
  assign due       = at_last(32'(idle_q), REFRESH_CYC);
  // A real edge takes priority over a refresh falling due on the same cycle
  assign refresh_o = due & ~edge_seen;
  assign start     = edge_seen | due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      idle_q <= '0;
      left_q <= '0;
      kind_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (start) begin
        idle_q <= '0;
        left_q <= LW'(PULSE_W);
        kind_q <= lvl_i;
      end else begin
        idle_q <= idle_q + IW'(1);
        if (left_q != '0) left_q <= left_q - LW'(1);
      end
    end
  end

  assign lines = encode_level(kind_q, left_q != '0);
  assign set_o = lines[1];
  assign clr_o = lines[0];
endmodule

// File: rtl/epl_rx.sv
module epl_rx
  import epl_pkg::*;
#(
  parameter int unsigned WDOG_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic expired_o,
  output logic usable_o,
  output logic wd_fire_o
);
  localparam int unsigned WW = cnt_width(WDOG_CYC);

  logic [WW-1:0] quiet_q;
  logic          lvl_q;
  logic          exp_q;

  assign usable_o  = pulse_usable(set_i, clr_i);
  assign wd_fire_o = ~usable_o & ~exp_q & at_last(32'(quiet_q), WDOG_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      exp_q   <= 1'b1;
      quiet_q <= '0;
    end else if (usable_o) begin
      lvl_q   <= set_i;
      exp_q   <= 1'b0;
      quiet_q <= '0;
    end else if (exp_q) begin
      lvl_q   <= 1'b0;
    end else if (wd_fire_o) begin
      lvl_q   <= 1'b0;
      exp_q   <= 1'b1;
      quiet_q <= '0;
    end else begin
      quiet_q <= quiet_q + WW'(1);
    end
  end

  assign lvl_o     = lvl_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_W     = 1,
  parameter int unsigned REFRESH_CYC = 100,
  parameter int unsigned WDOG_CYC    = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic set_out,
  output logic clr_out,
  input  logic set_in,
  input  logic clr_in,
  output logic data_out
);
  // Named internal events, visible to the bound checker
  logic lvl_sync;
  logic sync_rise;
  logic sync_fall;
  logic refresh_fire;
  logic rx_usable;
  logic wd_fire;
  logic wd_expired;

  epl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(data_in),
    .sync_o (lvl_sync)
  );

  epl_tx #(.PULSE_W(PULSE_W), .REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (lvl_sync),
    .set_o    (set_out),
    .clr_o    (clr_out),
    .rise_o   (sync_rise),
    .fall_o   (sync_fall),
    .refresh_o(refresh_fire)
  );

  epl_rx #(.WDOG_CYC(WDOG_CYC)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_in),
    .clr_i    (clr_in),
    .lvl_o    (data_out),
    .expired_o(wd_expired),
    .usable_o (rx_usable),
    .wd_fire_o(wd_fire)
  );
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int unsigned WDOG_CYC = 500
) (
  input logic clk,
  input logic rst_n,
  input logic set_out,
  input logic clr_out,
  input logic set_in,
  input logic clr_in,
  input logic data_out,
  input logic sync_rise,
  input logic sync_fall,
  input logic refresh_fire,
  input logic wd_fire,
  input logic wd_expired
);
  // Own count of edges since the last usable received pulse, saturating
  logic [31:0] silent_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   silent_q <= 32'(WDOG_CYC);
    else if (set_in ^ clr_in)     silent_q <= '0;
    else if (silent_q < 32'(WDOG_CYC)) silent_q <= silent_q + 32'd1;
  end

  assert_rise_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |=> set_out && !clr_out);

  assert_fall_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> clr_out && !set_out);

  assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_out && clr_out));

  assert_refresh_sends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |=> (set_out || clr_out));

  assert_set_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && !clr_in) |=> data_out);

  assert_clr_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_in && !set_in) |=> !data_out);

  assert_silence_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_q >= 32'(WDOG_CYC)) |-> !data_out);

  assert_expired_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> !data_out);

  assert_both_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && clr_in && !wd_fire) |=> $stable(data_out));

  assert_pulse_beats_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_q == 32'(WDOG_CYC) - 32'd1 && (set_in ^ clr_in)) |=> !wd_expired);
endmodule

bind edge_pulse_link epl_checker #(.WDOG_CYC(WDOG_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .set_out     (set_out),
  .clr_out     (clr_out),
  .set_in      (set_in),
  .clr_in      (clr_in),
  .data_out    (data_out),
  .sync_rise   (sync_rise),
  .sync_fall   (sync_fall),
  .refresh_fire(refresh_fire),
  .wd_fire     (wd_fire),
  .wd_expired  (wd_expired)
);

// File: tb/edge_pulse_link_bench.sv
module edge_pulse_link_bench;
  localparam int CLK_PERIOD_NS = 10;
  localparam int PULSE_W       = 1;
  localparam int REFRESH_CYC   = 100;
  localparam int WDOG_CYC      = 500;
  localparam int WATCHDOG_CYC  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic loop_en = 1'b0;
  logic inj_set = 1'b0;
  logic inj_clr = 1'b0;
  logic set_out, clr_out, data_out;
  logic set_in, clr_in;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  assign set_in = loop_en ? set_out : inj_set;
  assign clr_in = loop_en ? clr_out : inj_clr;

  edge_pulse_link #(
    .SYNC_STAGES(2), .PULSE_W(PULSE_W),
    .REFRESH_CYC(REFRESH_CYC), .WDOG_CYC(WDOG_CYC)
  ) u_edge_pulse_link (
    .clk(clk), .rst_n(rst_n), .data_in(din),
    .set_out(set_out), .clr_out(clr_out),
    .set_in(set_in), .clr_in(clr_in), .data_out(data_out)
  );

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: history of sampled inputs and plain integer state
  int hist[$];
  int m_idle, m_left, m_kind, m_q, m_quiet, m_dead;
  int m_sin, m_cin;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      hist = '{0, 0, 0, 0};
      m_idle = 0; m_left = 0; m_kind = 0;
      m_q = 0; m_quiet = 0; m_dead = 1;
    end else begin
      m_sin = loop_en ? ((m_left > 0 && m_kind == 1) ? 1 : 0) : int'(inj_set);
      m_cin = loop_en ? ((m_left > 0 && m_kind == 0) ? 1 : 0) : int'(inj_clr);
      hist.push_back(int'(din));
      void'(hist.pop_front());
      // hist[1]: level seen by the edge detector now, hist[0]: one cycle earlier
      if (hist[1] != hist[0] || m_idle == REFRESH_CYC - 1) begin
        m_idle = 0; m_left = PULSE_W; m_kind = hist[1];
      end else begin
        m_idle++;
        if (m_left > 0) m_left--;
      end
      if (m_sin != m_cin) begin
        m_q = m_sin; m_quiet = 0; m_dead = 0;
      end else if (m_dead == 0) begin
        if (m_quiet == WDOG_CYC - 1) begin m_dead = 1; m_q = 0; m_quiet = 0; end
        else m_quiet++;
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(set_out) == ((m_left > 0 && m_kind == 1) ? 1 : 0), "R1 R3 model set_out",
            int'(set_out), (m_left > 0 && m_kind == 1) ? 1 : 0);
      check(int'(clr_out) == ((m_left > 0 && m_kind == 0) ? 1 : 0), "R2 R3 model clr_out",
            int'(clr_out), (m_left > 0 && m_kind == 0) ? 1 : 0);
      check(int'(data_out) == m_q, "R4 R5 R6 R8 model data_out", int'(data_out), m_q);
    end
  end

  // Hang guard
  always @(posedge clk) begin
    if (cycles > WATCHDOG_CYC) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG_CYC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int n_set, n_clr;
  bit stayed;

  initial begin
    tick(5);
    check(data_out == 1'b0, "R7 reset data_out", int'(data_out), 0);
    check(set_out == 1'b0 && clr_out == 1'b0, "R7 reset pulse lines", int'({set_out, clr_out}), 0);
    @(negedge clk) rst_n = 1'b1;
    tick(1);
    check(data_out == 1'b0 && set_out == 1'b0 && clr_out == 1'b0, "R7 after release",
          int'({data_out, set_out, clr_out}), 0);
    loop_en = 1'b1;
    tick(20);

    // R1 latency of a rising change
    din = 1'b1;
    tick(2);
    check(set_out == 1'b0, "R1 no pulse before third edge", int'(set_out), 0);
    tick(1);
    check(set_out == 1'b1 && clr_out == 1'b0, "R1 set pulse on third edge", int'(set_out), 1);
    tick(1);
    check(data_out == 1'b1, "R4 set latched", int'(data_out), 1);

    // R3 refresh while idle, R9 held level
    n_set = 0; n_clr = 0; stayed = 1;
    for (int i = 0; i < 350; i++) begin
      tick(1);
      if (set_out) n_set++;
      if (clr_out) n_clr++;
      if (!data_out) stayed = 0;
    end
    check(n_set == 3, "R3 refresh set pulses in 350 idle cycles", n_set, 3);
    check(n_clr == 0, "R3 no clear refresh at high level", n_clr, 0);
    check(stayed, "R9 level held through refreshes", int'(stayed), 1);

    // R2 falling change
    din = 1'b0;
    tick(3);
    check(clr_out == 1'b1 && set_out == 1'b0, "R2 clear pulse on third edge", int'(clr_out), 1);
    tick(1);
    check(data_out == 1'b0, "R4 clear latched", int'(data_out), 0);

    // Toggle patterns
    for (int i = 0; i < 10; i++) begin din = ~din; tick(2); end
    for (int i = 0; i < 12; i++) begin din = ~din; tick(1); end
    for (int i = 0; i < 6; i++)  begin din = ~din; tick(3); end
    din = 1'b1;
    tick(10);
    check(data_out == 1'b1, "R9 follows after toggling", int'(data_out), 1);

    // R5 broken link
    loop_en = 1'b0;
    tick(WDOG_CYC + 10);
    check(data_out == 1'b0, "R5 silence forces low", int'(data_out), 0);
    din = 1'b0; tick(40); din = 1'b1; tick(60);
    check(data_out == 1'b0, "R5 stays low until a usable pulse", int'(data_out), 0);

    // R6 both lines while low
    inj_set = 1'b1; inj_clr = 1'b1; tick(1);
    inj_set = 1'b0; inj_clr = 1'b0; tick(1);
    check(data_out == 1'b0, "R6 both lines do not set", int'(data_out), 0);

    // Recover and R6 both lines while high
    inj_set = 1'b1; tick(1); inj_set = 1'b0;
    check(data_out == 1'b1, "R4 injected set", int'(data_out), 1);
    inj_set = 1'b1; inj_clr = 1'b1; tick(1);
    inj_set = 1'b0; inj_clr = 1'b0;
    check(data_out == 1'b1, "R6 both lines do not clear", int'(data_out), 1);

    // R6 both lines on the expiry edge do not restart the window
    inj_set = 1'b1; tick(1); inj_set = 1'b0;
    tick(WDOG_CYC - 1);
    inj_set = 1'b1; inj_clr = 1'b1; tick(1);
    inj_set = 1'b0; inj_clr = 1'b0;
    check(data_out == 1'b0, "R6 both lines on expiry edge do not rescue", int'(data_out), 0);

    // R8 usable pulse on the expiry edge
    inj_set = 1'b1; tick(1); inj_set = 1'b0;
    tick(WDOG_CYC - 1);
    inj_set = 1'b1; tick(1); inj_set = 1'b0;
    check(data_out == 1'b1, "R8 pulse wins over expiry", int'(data_out), 1);
    tick(WDOG_CYC - 1);
    check(data_out == 1'b1, "R8 fresh window still open", int'(data_out), 1);
    tick(1);
    check(data_out == 1'b0, "R5 expiry after exactly WDOG_CYC edges", int'(data_out), 0);

    // R4 injected clear then reconnect, R9
    inj_clr = 1'b1; tick(1); inj_clr = 1'b0;
    check(data_out == 1'b0, "R4 injected clear", int'(data_out), 0);
    loop_en = 1'b1;
    stayed = 1;
    tick(REFRESH_CYC + 5);
    for (int i = 0; i < 2 * WDOG_CYC; i++) begin
      tick(1);
      if (!data_out) stayed = 0;
    end
    check(stayed, "R9 reconnected link never expires", int'(stayed), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule